// File: doc/BRIEF.md
# Indirect Index-Data Register Window

This block is a small I/O-port slave that gives a narrow, low-address bus a path into a larger memory-mapped register file. It decodes a 32-byte I/O window that holds two dword registers: a pointer register and a data port. Software writes a target address into the pointer register. It then reads or writes the data port, and each data-port access is passed to a downstream register-file bus at the address held in the pointer.

An upstream access is a one-cycle request with an address, a write flag, write data and byte enables. The block answers with a one-cycle done pulse, and on a read the done pulse carries read data. Accesses to the pointer register and to unused offsets finish one cycle after the request. A data-port access raises a downstream request that carries the pointer as its address, together with the original byte enables, write data and write flag. The block holds that request until the downstream side asserts its ready/valid acknowledge, and it finishes the upstream access one cycle after that acknowledge. All values are little-endian, so byte lane k holds bits 8k+7:8k.

Top module: `idx_data_window`

## Requirements
- R1: After reset the pointer register reads 0 and no downstream request is pending.
- R2: A write to window offset 0x10 stores the write data ANDed with 0xFFC. Reading offset 0x10 returns that value zero-extended to 32 bits, so writing 0x13 reads back 0x10.
- R3: A read or write of offset 0x14 raises `dn_req` with `dn_addr` equal to the stored pointer, and with `dn_we`, `dn_wdata` and `dn_be` equal to the upstream write flag, data and byte enables. These outputs stay stable until `dn_ack` arrives.
- R4: One cycle after the cycle in which `dn_req` and `dn_ack` are both high, `up_done` pulses once and `dn_req` is low. For a read, `up_rdata` then equals the `dn_rdata` value seen at the acknowledge.
- R5: Reads at any window offset other than 0x10 and 0x14 return 0, and writes there change no state. Neither kind raises `dn_req`. Both finish one cycle after the request.
- R6: The pointer keeps its value across data-port accesses and does not increment, so repeated data accesses reach the same target address.
- R7: While an access is outstanding, `up_busy` is high and new upstream requests are ignored.
- R8: A pointer-register or unused-offset access raises `up_done` exactly one cycle after the `up_req` cycle. `up_rdata` is 0 whenever `up_done` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| up_req | input | 1 | Upstream access request, one cycle |
| up_we | input | 1 | Upstream write flag |
| up_addr | input | 5 | Byte offset within the window |
| up_wdata | input | 32 | Upstream write data |
| up_be | input | 4 | Upstream byte enables |
| up_busy | output | 1 | Access outstanding |
| up_done | output | 1 | Access complete pulse |
| up_rdata | output | 32 | Read data, valid with up_done |
| dn_req | output | 1 | Downstream request |
| dn_we | output | 1 | Downstream write flag |
| dn_addr | output | 12 | Downstream byte address |
| dn_wdata | output | 32 | Downstream write data |
| dn_be | output | 4 | Downstream byte enables |
| dn_ack | input | 1 | Downstream acknowledge |
| dn_rdata | input | 32 | Downstream read data |

## Verification
A corrupted pointer becomes visible on `dn_addr` at the next data-port access, and on the read data of the next pointer read, one cycle after that request. A stuck or lost request state shows up as a missing or extra `up_done` pulse, or as `dn_req` held high. The bench therefore checks, in every access, the exact cycle of completion and every downstream field. It does this with random acknowledge delays, as well as with directed masking and unused-offset cases.

// File: rtl/idx_data_window.sv
module idx_data_window #(
  parameter int DW = 32,
  parameter int AW = 12,
  parameter int WIN_AW = 5,
  parameter int IDX_OFS = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              up_req,
  input  logic              up_we,
  input  logic [WIN_AW-1:0] up_addr,
  input  logic [DW-1:0]     up_wdata,
  input  logic [DW/8-1:0]   up_be,
  output logic              up_busy,
  output logic              up_done,
  output logic [DW-1:0]     up_rdata,
  output logic              dn_req,
  output logic              dn_we,
  output logic [AW-1:0]     dn_addr,
  output logic [DW-1:0]     dn_wdata,
  output logic [DW/8-1:0]   dn_be,
  input  logic              dn_ack,
  input  logic [DW-1:0]     dn_rdata
);
  localparam int BEW = DW / 8;
  localparam int LSB = $clog2(BEW);
  localparam logic [WIN_AW-1:0] IDX_A = WIN_AW'(IDX_OFS);
  localparam logic [WIN_AW-1:0] DAT_A = WIN_AW'(IDX_OFS + BEW);
  localparam logic [AW-1:0] IDX_MASK = {{(AW-LSB){1'b1}}, {LSB{1'b0}}};

  logic [AW-1:0] idx_q;
  logic          pend_q;
  logic          done_q;
  logic [DW-1:0] rdata_q;
  logic          accept;
  logic          hit_idx, hit_dat;

  assign accept  = up_req && !pend_q;
  assign hit_idx = up_addr == IDX_A;
  assign hit_dat = up_addr == DAT_A;
  assign up_busy = pend_q;
  assign up_done = done_q;
  assign up_rdata = done_q ? rdata_q : '0;
  assign dn_req  = pend_q;
  assign dn_addr = idx_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx_q    <= '0;
      pend_q   <= 1'b0;
      done_q   <= 1'b0;
      rdata_q  <= '0;
      dn_we    <= 1'b0;
      dn_wdata <= '0;
      dn_be    <= '0;
    end else begin
      done_q  <= 1'b0;
      rdata_q <= '0;
      if (pend_q) begin
        if (dn_ack) begin
          pend_q  <= 1'b0;
          done_q  <= 1'b1;
          rdata_q <= dn_we ? '0 : dn_rdata;
        end
      end else if (accept) begin
        if (hit_dat) begin
          pend_q   <= 1'b1;
          dn_we    <= up_we;
          dn_wdata <= up_wdata;
          dn_be    <= up_be;
        end else begin
          done_q <= 1'b1;
          if (hit_idx) begin
            if (up_we) idx_q <= up_wdata[AW-1:0] & IDX_MASK;
            else rdata_q <= DW'(idx_q);
          end
        end
      end
    end
  end

  // R2
  idx_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
    idx_q[LSB-1:0] == '0);
  // R3
  dn_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dn_req && !dn_ack |=> dn_req && $stable(dn_addr) && $stable(dn_wdata) && $stable(dn_be) && $stable(dn_we));
  // R4
  dn_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dn_req && dn_ack |=> up_done && !dn_req);
  // R6
  idx_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dn_req |=> $stable(dn_addr));
  // R8
  rdata_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !up_done |-> up_rdata == '0);
  // R7
  no_req_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    up_done |-> !dn_req);
endmodule

// File: tb/sim_idx_data_window.sv
module sim_idx_data_window;
  localparam int CLK_P = 10;
  logic clk = 0, rst_n = 0;
  logic up_req = 0, up_we = 0;
  logic [4:0] up_addr = 0;
  logic [31:0] up_wdata = 0;
  logic [3:0] up_be = 0;
  logic up_busy, up_done, dn_req, dn_we, dn_ack = 0;
  logic [31:0] up_rdata, dn_wdata, dn_rdata = 0;
  logic [11:0] dn_addr;
  logic [3:0] dn_be;
  int checks = 0, errors = 0;
  logic [11:0] model_idx = 0;
  logic [31:0] seed = 32'd7;

  always #(CLK_P/2) clk = ~clk;

  idx_data_window u0 (.*);

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  function automatic logic [11:0] mask_idx(input logic [31:0] v);
    return v[11:0] & 12'hFFC;
  endfunction

  task automatic issue(input logic we, input logic [4:0] a, input logic [31:0] d, input logic [3:0] be);
    @(negedge clk);
    up_req = 1; up_we = we; up_addr = a; up_wdata = d; up_be = be;
    @(negedge clk);
    up_req = 0;
  endtask

  // plain access: done expected at the first negedge after request edge
  task automatic plain(input logic we, input logic [4:0] a, input logic [31:0] d, input logic [31:0] exp, input string r);
    issue(we, a, d, 4'hF);
    chk({r, " done"}, {31'd0, up_done}, 32'd1);
    chk({r, " rdata"}, up_rdata, exp);
    chk({r, " no dn_req"}, {31'd0, dn_req}, 32'd0);
    if (we && a == 5'h10) model_idx = mask_idx(d);
  endtask

  task automatic data_acc(input logic we, input logic [31:0] d, input logic [3:0] be, input int delay, input logic [31:0] rd);
    issue(we, 5'h14, d, be);
    chk("R3 dn_req", {31'd0, dn_req}, 32'd1);
    chk("R3 dn_addr R6", {20'd0, dn_addr}, {20'd0, model_idx});
    chk("R3 dn_we", {31'd0, dn_we}, {31'd0, we});
    chk("R3 dn_wdata", dn_wdata, d);
    chk("R3 dn_be", {28'd0, dn_be}, {28'd0, be});
    for (int i = 0; i < delay; i++) begin
      up_req = 1; up_addr = 5'h10; up_we = 1; up_wdata = 32'hFFF;
      @(negedge clk);
      up_req = 0;
      chk("R7 busy", {31'd0, up_busy}, 32'd1);
      chk("R3 held", {20'd0, dn_addr}, {20'd0, model_idx});
    end
    dn_ack = 1; dn_rdata = rd;
    @(negedge clk);
    dn_ack = 0; dn_rdata = 0;
    chk("R4 done", {31'd0, up_done}, 32'd1);
    chk("R4 rdata", up_rdata, we ? 32'd0 : rd);
    chk("R4 dn_req low", {31'd0, dn_req}, 32'd0);
    @(negedge clk);
    chk("R4 single pulse", {31'd0, up_done}, 32'd0);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        chk("R1 dn_req", {31'd0, dn_req}, 32'd0);
        plain(0, 5'h10, 0, 32'd0, "R1 idx");
        plain(1, 5'h10, 32'h13, 32'd0, "R2 wr");
        plain(0, 5'h10, 0, 32'h10, "R2 rd 0x13");
        plain(1, 5'h10, 32'hFFFF_FFFF, 32'd0, "R2 wr all");
        plain(0, 5'h10, 0, 32'hFFC, "R2 rd mask");
        plain(1, 5'h08, 32'h123, 32'd0, "R5 wr unused");
        plain(0, 5'h08, 0, 32'd0, "R5 rd unused");
        plain(0, 5'h10, 0, 32'hFFC, "R5 idx untouched");
        plain(1, 5'h11, 32'h40, 32'd0, "R5 wr unaligned");
        plain(0, 5'h10, 0, 32'hFFC, "R5 idx after 0x11");
        data_acc(0, 32'h0, 4'hF, 0, 32'hA5A5_1234);
        data_acc(1, 32'hDEAD_BEEF, 4'h3, 2, 32'h5555_5555);
        plain(0, 5'h10, 0, {20'd0, model_idx}, "R6 idx kept");
        data_acc(0, 32'h0, 4'hF, 1, 32'h0BAD_F00D);
        for (int n = 0; n < 60; n++) begin
          seed = $urandom(seed);
          case (seed[1:0])
            2'd0: plain(1, 5'h10, $urandom, 32'd0, "R2 rand wr");
            2'd1: plain(0, 5'h10, 0, {20'd0, model_idx}, "R2 rand rd");
            2'd2: begin
              logic [4:0] a;
              a = 5'($urandom);
              if (a == 5'h10 || a == 5'h14) a = 5'h1C;
              plain(1'($urandom), a, $urandom, 32'd0, "R5 rand");
            end
            default: data_acc(1'($urandom), $urandom, 4'($urandom), int'($urandom % 4), $urandom);
          endcase
        end
      end
      begin
        repeat (20000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog actual=hung expected=done");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule